// File: doc/BRIEF.md
# Capture Buffer State Manager

This block manages a pool of capture buffer handles (small integer indices) for a periodic data-capture path. Each handle is always in exactly one place: the free queue, the single in-flight slot, the filled queue, or the reader slot. When the data source signals that a new capture is ready, the block takes the oldest free handle and starts a transfer into it. If no handle is free, the capture is discarded and a saturating drop counter advances. When the transfer engine reports completion, the in-flight handle is appended to the filled queue. A reader takes the oldest filled handle, works on the buffer it names, and hands it back. The handle then returns to the free queue.

Software starts a capture session by requesting an enable with a pool size. The size must be between a minimum and the pool capacity, and the free queue is then loaded with handles 0 to N-1 in ascending order. A disable request stops new captures at once. The block then waits until the in-flight slot is empty and clears both queues. A handle that the reader returns after a disable, or after a later re-enable, is dropped and does not rejoin the free queue. Re-enabling is the way to change the buffer size, so a handle from an old session never mixes with the new one.

Top module: `cbm_buffer_manager`

## Requirements
- R1: After synchronous reset the block is disabled, not draining, both queue counts are 0, nothing is in flight, the reader holds nothing, the drop count is 0 and the error flag is clear.
- R2: An enable request while disabled with en_count N, where MIN_POOL <= N <= POOL_MAX, sets enabled and pulses en_ok for one cycle after the request edge. The free queue then holds handles 0..N-1 in ascending order. Any other N pulses en_fail for one cycle and leaves the block disabled.
- R3: An enable request while enabled or draining, and a disable request while disabled or draining, change no output.
- R4: A data-ready event while enabled, with nothing in flight and the free queue not empty, pulses xfer_start for one cycle after the edge. It sets inflight with xfer_idx equal to the old free-queue head, and free_cnt drops by one.
- R5: A data-ready event while enabled with nothing in flight and an empty free queue increments drop_cnt, which saturates at 2^DROP_W-1. Events while disabled, draining or with a transfer in flight are ignored.
- R6: At most one handle is in flight. xfer_idx is held constant while inflight is set.
- R7: xfer_done while inflight appends the in-flight handle to the filled-queue tail and clears inflight. xfer_done with nothing in flight sets xfer_err, which stays set until reset.
- R8: rd_take while the reader holds nothing and the filled queue is not empty moves the filled head into the reader slot (rd_valid, rd_idx). rd_done while holding releases it and appends it to the free-queue tail if the block is enabled in the same session.
- R9: Both queues are first-in first-out. A pop in the same cycle as a push into an empty queue sees the queue as empty.
- R10: A disable request while enabled clears enabled and sets draining on the next edge. Draining lasts while a transfer is in flight. On the first edge with nothing in flight, both queues are emptied and draining clears.
- R11: A handle returned by rd_done while disabled or draining, or taken in an earlier session, is discarded, so free_cnt does not grow.
- R12: free_cnt + filled_cnt + inflight + rd_valid never grows while enabled. It only changes by the moves above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_req | input | 1 | Request to start a capture session |
| en_count | input | CNT_W | Pool size for the enable request |
| dis_req | input | 1 | Request to end the capture session |
| evt_ready | input | 1 | A new capture is ready to be transferred |
| xfer_done | input | 1 | The transfer engine finished the current transfer |
| rd_take | input | 1 | Reader takes the oldest filled handle |
| rd_done | input | 1 | Reader hands back its handle |
| enabled | output | 1 | Session active, captures accepted |
| draining | output | 1 | Disable pending, waiting for in-flight transfer |
| en_ok | output | 1 | One-cycle pulse: enable accepted |
| en_fail | output | 1 | One-cycle pulse: enable refused |
| xfer_start | output | 1 | One-cycle pulse: start transfer into xfer_idx |
| xfer_idx | output | IDX_W | Handle currently in flight |
| inflight | output | 1 | A transfer is in flight |
| rd_valid | output | 1 | Reader slot holds a handle |
| rd_idx | output | IDX_W | Handle held by the reader |
| free_cnt | output | CNT_W | Entries in the free queue |
| filled_cnt | output | CNT_W | Entries in the filled queue |
| drop_cnt | output | DROP_W | Saturating count of discarded captures |
| xfer_err | output | 1 | Sticky: completion seen with nothing in flight |

## Verification
The assertions check on every cycle that a transfer starts only from an enabled, idle slot and never twice in a row. They also check that the drop count moves by at most one, that the error flag is sticky and that it is raised by a stray completion. Further per-cycle checks cover the end of a drain, which must leave empty pools, and a handle total that never grows inside a session. Only the bench scenarios show the queue order, which handle is chosen, the discard of handles returned from an old session, and the saturation value of the drop counter. The bench compares these against a queue-level model under directed and random traffic.

// File: rtl/cbm_pkg.sv
// Package: shared types and helpers for the capture buffer manager.
// Assumes: nothing beyond IEEE 1800-2017.
package cbm_pkg;

    // Session state of the manager.
    typedef enum logic [1:0] {
        SESS_OFF   = 2'd0,
        SESS_ON    = 2'd1,
        SESS_DRAIN = 2'd2
    } sess_e;

endpackage

// File: rtl/cbm_index_fifo.sv
// Module: circular queue of buffer handles.
// Supports push at the tail, pop at the head, a clear, and a load that
// fills the queue with handles 0..load_n-1 in ascending order.
// Assumes: the caller never pops an empty queue. Clear wins over load,
// load wins over push and pop. Push into a full queue is dropped.
module cbm_index_fifo #(
    parameter  int DEPTH = 64,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] load_n,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    input  logic             pop,
    output logic [IDX_W-1:0] head_idx,
    output logic [CNT_W-1:0] count,
    output logic             empty
);

    logic [IDX_W-1:0] mem_q [DEPTH];
    logic [IDX_W-1:0] head_q;
    logic [IDX_W-1:0] tail_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push;
    logic             do_pop;

    // Advance a pointer by one with wrap at DEPTH.
    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    // Qualify push and pop against the current fill level.
    always_comb begin
        do_push = push && (int'(cnt_q) < DEPTH);
        do_pop  = pop && (cnt_q != '0);
    end

    // Pointer and count update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            head_q <= '0;
            tail_q <= (int'(load_n) >= DEPTH) ? '0 : IDX_W'(load_n);
            cnt_q  <= load_n;
        end else begin
            if (do_push) tail_q <= bump(tail_q);
            if (do_pop)  head_q <= bump(head_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    // Storage write: ascending fill on load, otherwise tail write on push.
    always_ff @(posedge clk) begin
        if (load && rst_n && !clear) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= IDX_W'(i);
        end else if (do_push && rst_n && !clear) begin
            mem_q[tail_q] <= push_idx;
        end
    end

    // Head and status outputs.
    always_comb begin
        head_idx = mem_q[head_q];
        count    = cnt_q;
        empty    = (cnt_q == '0);
    end

endmodule

// File: rtl/cbm_session_ctrl.sv
// Module: session controller for the capture buffer manager.
// Accepts enable and disable requests, checks the requested pool size,
// drains the in-flight slot before ending a session and keeps a session
// number that tags handles given to the reader.
// Assumes: inflight is the registered in-flight flag of the parent.
module cbm_session_ctrl #(
    parameter  int POOL_MAX = 64,
    parameter  int MIN_POOL = 8,
    parameter  int GEN_W    = 4,
    localparam int CNT_W    = $clog2(POOL_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_req,
    input  logic [CNT_W-1:0]     en_count,
    input  logic                 dis_req,
    input  logic                 inflight,
    output cbm_pkg::sess_e       state,
    output logic                 load,
    output logic                 clear,
    output logic                 ok_pulse,
    output logic                 fail_pulse,
    output logic [GEN_W-1:0]     gen
);
    import cbm_pkg::*;

    sess_e            st_q;
    logic [GEN_W-1:0] gen_q;
    logic             size_ok;
    logic             ok_q;
    logic             fail_q;

    // Requested pool size must lie inside the allowed range.
    always_comb size_ok = (int'(en_count) >= MIN_POOL) && (int'(en_count) <= POOL_MAX);

    // Load and clear strobes for the queues.
    always_comb begin
        load  = (st_q == SESS_OFF) && en_req && size_ok;
        clear = (st_q == SESS_DRAIN) && !inflight;
    end

    // Session state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SESS_OFF;
        end else begin
            unique case (st_q)
                SESS_OFF:   if (load)    st_q <= SESS_ON;
                SESS_ON:    if (dis_req) st_q <= SESS_DRAIN;
                SESS_DRAIN: if (clear)   st_q <= SESS_OFF;
                default:                 st_q <= SESS_OFF;
            endcase
        end
    end

    // Result pulses and session number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q   <= 1'b0;
            fail_q <= 1'b0;
            gen_q  <= '0;
        end else begin
            ok_q   <= load;
            fail_q <= (st_q == SESS_OFF) && en_req && !size_ok;
            if (load) gen_q <= gen_q + 1'b1;
        end
    end

    always_comb begin
        state      = st_q;
        ok_pulse   = ok_q;
        fail_pulse = fail_q;
        gen        = gen_q;
    end

endmodule

// File: rtl/cbm_sat_counter.sv
// Module: saturating event counter.
// Assumes: inc is a single-cycle strobe; the count holds at its maximum.
module cbm_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);

    logic [W-1:0] cnt_q;

    // Count up, stop at the all-ones value.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (inc && !(&cnt_q))  cnt_q <= cnt_q + 1'b1;
    end

    always_comb value = cnt_q;

endmodule

// File: rtl/cbm_buffer_manager.sv
// Module: capture buffer state manager (top).
// Moves buffer handles from a free queue through one in-flight slot into
// a filled queue, hands the oldest filled handle to one reader and takes
// it back into the free queue. Counts captures lost for lack of a free
// handle and flags completions that arrive with nothing in flight.
// Assumes: all request inputs are single-cycle strobes synchronous to clk.
module cbm_buffer_manager #(
    parameter  int POOL_MAX = 64,
    parameter  int MIN_POOL = 8,
    parameter  int DROP_W   = 16,
    parameter  int GEN_W    = 4,
    localparam int IDX_W    = (POOL_MAX > 1) ? $clog2(POOL_MAX) : 1,
    localparam int CNT_W    = $clog2(POOL_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_req,
    input  logic [CNT_W-1:0]  en_count,
    input  logic              dis_req,
    input  logic              evt_ready,
    input  logic              xfer_done,
    input  logic              rd_take,
    input  logic              rd_done,
    output logic              enabled,
    output logic              draining,
    output logic              en_ok,
    output logic              en_fail,
    output logic              xfer_start,
    output logic [IDX_W-1:0]  xfer_idx,
    output logic              inflight,
    output logic              rd_valid,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [CNT_W-1:0]  free_cnt,
    output logic [CNT_W-1:0]  filled_cnt,
    output logic [DROP_W-1:0] drop_cnt,
    output logic              xfer_err
);
    import cbm_pkg::*;

    sess_e            state;
    logic             q_load;
    logic             q_clear;
    logic [GEN_W-1:0] gen;

    logic [IDX_W-1:0] free_head;
    logic             free_empty;
    logic [IDX_W-1:0] fill_head;
    logic             fill_empty;

    logic             inf_q;
    logic [IDX_W-1:0] inf_idx_q;
    logic             start_q;
    logic             held_q;
    logic [IDX_W-1:0] held_idx_q;
    logic [GEN_W-1:0] held_gen_q;
    logic             err_q;

    logic             evt_ok;
    logic             do_start;
    logic             do_drop;
    logic             do_complete;
    logic             do_take;
    logic             do_return;
    logic             keep_ret;

    // Session control: enable checks, drain and session numbering.
    cbm_session_ctrl #(
        .POOL_MAX (POOL_MAX),
        .MIN_POOL (MIN_POOL),
        .GEN_W    (GEN_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_req     (en_req),
        .en_count   (en_count),
        .dis_req    (dis_req),
        .inflight   (inf_q),
        .state      (state),
        .load       (q_load),
        .clear      (q_clear),
        .ok_pulse   (en_ok),
        .fail_pulse (en_fail),
        .gen        (gen)
    );

    // Decode the moves of this cycle from the current state.
    always_comb begin
        evt_ok      = evt_ready && (state == SESS_ON) && !inf_q;
        do_start    = evt_ok && !free_empty;
        do_drop     = evt_ok && free_empty;
        do_complete = xfer_done && inf_q;
        do_take     = rd_take && !held_q && !fill_empty;
        do_return   = rd_done && held_q;
        keep_ret    = do_return && (state == SESS_ON) && (held_gen_q == gen);
    end

    // Free queue: loaded on enable, popped on start, refilled by the reader.
    cbm_index_fifo #(.DEPTH(POOL_MAX)) u_free_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (q_clear),
        .load     (q_load),
        .load_n   (en_count),
        .push     (keep_ret),
        .push_idx (held_idx_q),
        .pop      (do_start),
        .head_idx (free_head),
        .count    (free_cnt),
        .empty    (free_empty)
    );

    // Filled queue: appended on completion, popped by the reader.
    cbm_index_fifo #(.DEPTH(POOL_MAX)) u_fill_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (q_clear),
        .load     (1'b0),
        .load_n   ('0),
        .push     (do_complete),
        .push_idx (inf_idx_q),
        .pop      (do_take),
        .head_idx (fill_head),
        .count    (filled_cnt),
        .empty    (fill_empty)
    );

    // In-flight slot and transfer start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inf_q     <= 1'b0;
            inf_idx_q <= '0;
            start_q   <= 1'b0;
        end else begin
            start_q <= do_start;
            if (do_start) begin
                inf_q     <= 1'b1;
                inf_idx_q <= free_head;
            end else if (do_complete) begin
                inf_q     <= 1'b0;
            end
        end
    end

    // Reader slot with the session number of the handle it holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q     <= 1'b0;
            held_idx_q <= '0;
            held_gen_q <= '0;
        end else if (do_take) begin
            held_q     <= 1'b1;
            held_idx_q <= fill_head;
            held_gen_q <= gen;
        end else if (do_return) begin
            held_q     <= 1'b0;
        end
    end

    // Sticky flag for a completion with nothing in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)                     err_q <= 1'b0;
        else if (xfer_done && !inf_q)   err_q <= 1'b1;
    end

    // Lost-capture counter.
    cbm_sat_counter #(.W(DROP_W)) u_drop (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (do_drop),
        .value (drop_cnt)
    );

    // Status outputs.
    always_comb begin
        enabled    = (state == SESS_ON);
        draining   = (state == SESS_DRAIN);
        xfer_start = start_q;
        xfer_idx   = inf_idx_q;
        inflight   = inf_q;
        rd_valid   = held_q;
        rd_idx     = held_idx_q;
        xfer_err   = err_q;
    end

endmodule

// File: rtl/cbm_buffer_manager_chk.sv
// Module: assertion checker for the capture buffer manager, bound to the top.
// Assumes: observes top-level ports only.
module cbm_buffer_manager_chk #(
    parameter int POOL_MAX = 64,
    parameter int MIN_POOL = 8,
    parameter int DROP_W   = 16,
    parameter int IDX_W    = 6,
    parameter int CNT_W    = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_req,
    input logic [CNT_W-1:0]  en_count,
    input logic              xfer_done,
    input logic              enabled,
    input logic              draining,
    input logic              en_ok,
    input logic              xfer_start,
    input logic              inflight,
    input logic              rd_valid,
    input logic [CNT_W-1:0]  free_cnt,
    input logic [CNT_W-1:0]  filled_cnt,
    input logic [DROP_W-1:0] drop_cnt,
    input logic              xfer_err
);

    logic [CNT_W+1:0] total;

    // Handle total across all four places.
    always_comb total = (CNT_W+2)'(free_cnt) + (CNT_W+2)'(filled_cnt)
                      + (CNT_W+2)'(inflight) + (CNT_W+2)'(rd_valid);

    assert_enable_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en_ok |-> (enabled && free_cnt == $past(en_count) && filled_cnt == '0 && !inflight));

    assert_start_needs_session_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> ($past(enabled) && inflight));

    assert_one_inflight_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> !$past(inflight));

    assert_drop_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (drop_cnt == $past(drop_cnt) || drop_cnt == $past(drop_cnt) + 1'b1));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |=> xfer_err);

    assert_err_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !inflight) |=> xfer_err);

    assert_state_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({enabled, draining}));

    assert_drain_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(draining) |-> (free_cnt == '0 && filled_cnt == '0 && !inflight && !enabled));

    assert_no_growth_R12: assert property (@(posedge clk) disable iff (!rst_n)
        enabled |=> (total <= $past(total)));

endmodule

bind cbm_buffer_manager cbm_buffer_manager_chk #(
    .POOL_MAX (POOL_MAX),
    .MIN_POOL (MIN_POOL),
    .DROP_W   (DROP_W),
    .IDX_W    (IDX_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_req     (en_req),
    .en_count   (en_count),
    .xfer_done  (xfer_done),
    .enabled    (enabled),
    .draining   (draining),
    .en_ok      (en_ok),
    .xfer_start (xfer_start),
    .inflight   (inflight),
    .rd_valid   (rd_valid),
    .free_cnt   (free_cnt),
    .filled_cnt (filled_cnt),
    .drop_cnt   (drop_cnt),
    .xfer_err   (xfer_err)
);

// File: tb/test_cbm_buffer_manager.sv
module test_cbm_buffer_manager;

    localparam int CLK_PERIOD = 10;
    localparam int POOL_MAX   = 64;
    localparam int MIN_POOL   = 8;
    localparam int DROP_W     = 4;
    localparam int IDX_W      = 6;
    localparam int CNT_W      = 7;
    localparam int DROP_MAX   = (1 << DROP_W) - 1;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en_req = 1'b0;
    logic [CNT_W-1:0]  en_count = '0;
    logic              dis_req = 1'b0;
    logic              evt_ready = 1'b0;
    logic              xfer_done = 1'b0;
    logic              rd_take = 1'b0;
    logic              rd_done = 1'b0;
    logic              enabled, draining, en_ok, en_fail, xfer_start, inflight, rd_valid, xfer_err;
    logic [IDX_W-1:0]  xfer_idx, rd_idx;
    logic [CNT_W-1:0]  free_cnt, filled_cnt;
    logic [DROP_W-1:0] drop_cnt;

    cbm_buffer_manager #(
        .POOL_MAX (POOL_MAX),
        .MIN_POOL (MIN_POOL),
        .DROP_W   (DROP_W),
        .GEN_W    (4)
    ) i_cbm_buffer_manager (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference model state (0 off, 1 on, 2 draining)
    int m_st, m_gen, m_drop, m_infidx, m_hidx, m_hgen;
    bit m_inf, m_held, m_err, m_ok, m_fail, m_start;
    int m_free[$];
    int m_fill[$];

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        m_st = 0; m_gen = 0; m_drop = 0; m_infidx = 0; m_hidx = 0; m_hgen = 0;
        m_inf = 0; m_held = 0; m_err = 0; m_ok = 0; m_fail = 0; m_start = 0;
        m_free.delete(); m_fill.delete();
    endfunction

    // One cycle of the requirement-level model, from pre-edge values.
    function automatic void model_step(bit e, int n, bit d, bit ev, bit xd, bit tk, bit dn);
        int  st0 = m_st;
        int  gen0 = m_gen;
        bit  inf0 = m_inf;
        bit  held0 = m_held;
        bit  do_clear = 0;
        m_ok = 0; m_fail = 0; m_start = 0;
        if (st0 == 0 && e) begin
            if (n >= MIN_POOL && n <= POOL_MAX) begin
                m_free.delete();
                for (int i = 0; i < n; i++) m_free.push_back(i);
                m_gen = (m_gen + 1) % 16; m_st = 1; m_ok = 1;
            end else m_fail = 1;
        end else if (st0 == 1 && d) m_st = 2;
        else if (st0 == 2 && !inf0) begin m_st = 0; do_clear = 1; end
        if (ev && st0 == 1 && !inf0) begin
            if (m_free.size() > 0) begin
                m_infidx = m_free.pop_front(); m_inf = 1; m_start = 1;
            end else if (m_drop < DROP_MAX) m_drop++;
        end
        if (tk && !held0 && m_fill.size() > 0) begin
            m_hidx = m_fill.pop_front(); m_held = 1; m_hgen = gen0;
        end
        if (xd) begin
            if (inf0) begin m_fill.push_back(m_infidx); m_inf = 0; end
            else m_err = 1;
        end
        if (dn && held0) begin
            m_held = 0;
            if (st0 == 1 && m_hgen == gen0) m_free.push_back(m_hidx);
        end
        if (do_clear) begin m_free.delete(); m_fill.delete(); end
    endfunction

    task automatic compare_all();
        int sum_act = int'(free_cnt) + int'(filled_cnt) + int'(inflight) + int'(rd_valid);
        int sum_exp = m_free.size() + m_fill.size() + int'(m_inf) + int'(m_held);
        check("R2 enabled", int'(enabled), int'(m_st == 1));
        check("R10 draining", int'(draining), int'(m_st == 2));
        check("R2 en_ok", int'(en_ok), int'(m_ok));
        check("R2 en_fail", int'(en_fail), int'(m_fail));
        check("R4 xfer_start", int'(xfer_start), int'(m_start));
        check("R6 inflight", int'(inflight), int'(m_inf));
        if (m_inf) check("R6 xfer_idx", int'(xfer_idx), m_infidx);
        check("R8 rd_valid", int'(rd_valid), int'(m_held));
        if (m_held) check("R8 rd_idx", int'(rd_idx), m_hidx);
        check("R9 free_cnt", int'(free_cnt), m_free.size());
        check("R9 filled_cnt", int'(filled_cnt), m_fill.size());
        check("R5 drop_cnt", int'(drop_cnt), m_drop);
        check("R7 xfer_err", int'(xfer_err), int'(m_err));
        check("R12 handle total", sum_act, sum_exp);
    endtask

    task automatic step(bit e = 0, int n = 0, bit d = 0, bit ev = 0, bit xd = 0,
                        bit tk = 0, bit dn = 0);
        en_req = e; en_count = CNT_W'(n); dis_req = d; evt_ready = ev;
        xfer_done = xd; rd_take = tk; rd_done = dn;
        model_step(e, n, d, ev, xd, tk, dn);
        @(posedge clk);
        @(negedge clk);
        en_req = 0; dis_req = 0; evt_ready = 0; xfer_done = 0; rd_take = 0; rd_done = 0;
        compare_all();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd24681357));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_all();
        check("R1 reset enabled", int'(enabled), 0);
        check("R1 reset free_cnt", int'(free_cnt), 0);
        check("R1 reset drop_cnt", int'(drop_cnt), 0);

        // R2 out-of-range sizes refused
        step(.e(1), .n(5));
        check("R2 refuse 5", int'(en_fail), 1);
        step(.e(1), .n(65));
        check("R2 refuse 65", int'(enabled), 0);
        // R3 disable while disabled has no effect
        step(.d(1));
        check("R3 disable when off", int'(draining), 0);
        // R2 valid enable
        step(.e(1), .n(8));
        check("R2 free after enable", int'(free_cnt), 8);
        // R3 second enable ignored
        step(.e(1), .n(12));
        check("R3 enable when on", int'(free_cnt), 8);

        // R4/R6/R7/R9 fill all buffers, ascending order
        for (int k = 0; k < 8; k++) begin
            step(.ev(1));
            check("R4 start index order", int'(xfer_idx), k);
            step(.ev(1));   // ignored while in flight (R5)
            step(.xd(1));
        end
        check("R7 filled all", int'(filled_cnt), 8);
        // R5 drop on empty free queue, saturation
        for (int k = 0; k < 20; k++) step(.ev(1));
        check("R5 drop saturates", int'(drop_cnt), DROP_MAX);
        // R7 stray completion
        step(.xd(1));
        check("R7 stray completion", int'(xfer_err), 1);
        // R8/R9 reader order and return
        for (int k = 0; k < 3; k++) begin
            step(.tk(1));
            check("R9 reader order", int'(rd_idx), k);
            step(.dn(1));
        end
        check("R8 returned to free", int'(free_cnt), 3);
        // R10 disable with a transfer in flight
        step(.ev(1));
        step(.tk(1));
        step(.d(1));
        check("R10 draining while in flight", int'(draining), 1);
        step(.ev(1));
        check("R10 no start while draining", int'(xfer_start), 0);
        step(.xd(1));
        step();
        check("R10 pools cleared", int'(free_cnt) + int'(filled_cnt), 0);
        // R11 return after disable discarded
        step(.dn(1));
        check("R11 discard after disable", int'(free_cnt), 0);
        // R11 return from older session discarded
        step(.e(1), .n(10));
        step(.ev(1)); step(.xd(1)); step(.tk(1));
        step(.d(1)); step(); step(.e(1), .n(9));
        step(.dn(1));
        check("R11 discard old session", int'(free_cnt), 9);

        // Random traffic
        for (int c = 0; c < 4000; c++) begin
            bit e  = ($urandom_range(0, 99) < 2);
            bit d  = ($urandom_range(0, 99) < 1);
            step(.e(e), .n(int'($urandom_range(4, 70))), .d(d),
                 .ev($urandom_range(0, 99) < 30), .xd($urandom_range(0, 99) < 25),
                 .tk($urandom_range(0, 99) < 30), .dn($urandom_range(0, 99) < 25));
        end
        finish_run();
    end

endmodule